// File: doc/BRIEF.md
# Pulse-Qualified Saturating Trim Counter

This block is the digital core of a single-wire trim adjuster. External comparators resolve a three-level control line into two flags: one is active while the line is pulled high, the other while it is pulled low. The block brings both flags into the clock domain and measures how long each pulse lasts. A pulse that lasts long enough moves a 7-bit setting by one step when it ends. A low pulse steps the setting up and a high pulse steps it down. The setting stops at both ends of its range and never wraps.

At power-on the setting is taken from a non-volatile shadow word. The first qualified pulse after power-on is thrown away, because the comparators may start in an arbitrary state. A program strobe sends the current setting back to the shadow as a one-cycle store request with a data word. An enable input blocks all adjustment while it is low.

Top module: `trim_ctrl_top`

## Requirements
- R1: One clock after reset is released, the block loads `nv_data` into `setting`. The code is 0..127 and stands for levels 1..128. It holds that value until a valid adjustment arrives, and `store_req` is 0 out of reset.
- R2: A low pulse lasts N clock cycles at the `ctl_lo_raw` input, with N > ACCEPT_CYC = (CLK_HZ/1000)*200/1000. When the pulse ends, `setting` rises by exactly 1.
- R3: A high pulse on `ctl_hi_raw` that lasts N > ACCEPT_CYC cycles lowers `setting` by exactly 1 when the pulse ends.
- R4: A pulse of N <= ACCEPT_CYC cycles leaves `setting` unchanged. This includes every pulse shorter than REJECT_CYC = (CLK_HZ/1000)*20/1000.
- R5: After each reset, the first qualified pulse that arrives while `enable` is high is discarded. Every later qualified pulse acts.
- R6: When `setting` is 127, an increment leaves it at 127.
- R7: When `setting` is 0, a decrement leaves it at 0.
- R8: While `enable` is 0, pulses change nothing. This includes the first-pulse discard state, which such a pulse does not use up.
- R9: When `prog` rises, `store_req` is 1 for exactly one cycle, on the cycle after the rise, and `store_data` carries the value `setting` had in the rise cycle. Holding `prog` high does not raise a second request.
- R10: A pulse far longer than ACCEPT_CYC produces exactly one step.
- R11: If both flags are active together, the pulse being measured is dropped. No step follows until both flags have returned inactive and a new qualified pulse completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; its release marks power-on |
| ctl_hi_raw | input | 1 | Asynchronous comparator flag: control line driven high |
| ctl_lo_raw | input | 1 | Asynchronous comparator flag: control line driven low |
| enable | input | 1 | Synchronous adjustment enable |
| prog | input | 1 | Synchronous program strobe; its rising edge stores the setting |
| nv_data | input | 7 | Non-volatile shadow word read at power-on |
| setting | output | 7 | Current trim code, 0..127 |
| store_req | output | 1 | One-cycle request to write the shadow |
| store_data | output | 7 | Word to write with `store_req` |

## Verification
The assertions assume that `enable` and `prog` are synchronous to the clock and that `nv_data` is stable through the cycle after reset is released. Only the two comparator flags are treated as asynchronous. The bench changes every input on the falling clock edge. It holds `nv_data` constant across each reset and keeps `enable` unchanged for the whole length of a pulse. The bench also assumes that a pulse is a clean level held for a whole number of clock cycles, so pulse widths fall exactly on either side of ACCEPT_CYC. It drives both flags at once only in the invalid-condition scenario.

// File: rtl/trim_pkg.sv
package trim_pkg;

    typedef enum logic [1:0] {
        Q_IDLE    = 2'd0,
        Q_MEAS_LO = 2'd1,
        Q_MEAS_HI = 2'd2,
        Q_ABORT   = 2'd3
    } qual_state_e;

    // Cycles spanned by a duration in microseconds at a clock rate in Hz.
    function automatic int cycles_for_us(input int hz, input int us);
        return (hz / 1000) * us / 1000;
    endfunction

endpackage

// File: rtl/trim_sync.sv
module trim_sync #(
    parameter int NBITS  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] async_i,
    output logic [NBITS-1:0] sync_o
);

    for (genvar b = 0; b < NBITS; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/trim_pulse_qual.sv
module trim_pulse_qual
    import trim_pkg::*;
#(
    parameter int CLK_HZ    = 10_000_000,
    parameter int ACCEPT_US = 200,
    parameter int REJECT_US = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flag_hi,
    input  logic flag_lo,
    output logic step_up,
    output logic step_dn
);

    localparam int ACCEPT_CYC = cycles_for_us(CLK_HZ, ACCEPT_US);
    localparam int REJECT_CYC = cycles_for_us(CLK_HZ, REJECT_US);
    localparam int CW         = $clog2(ACCEPT_CYC + 2);
    localparam logic [CW-1:0] W_SAT = CW'(ACCEPT_CYC + 1);

    typedef struct packed {
        qual_state_e    st;
        logic [CW-1:0]  w;
        logic           up;
        logic           dn;
    } qual_regs_t;

    qual_regs_t r_d, r_q;

    always_comb begin
        r_d    = r_q;
        r_d.up = 1'b0;
        r_d.dn = 1'b0;
        unique case (r_q.st)
            Q_IDLE: begin
                if (flag_hi && flag_lo) begin
                    r_d.st = Q_ABORT;
                end else if (flag_lo) begin
                    r_d.st = Q_MEAS_LO;
                    r_d.w  = CW'(1);
                end else if (flag_hi) begin
                    r_d.st = Q_MEAS_HI;
                    r_d.w  = CW'(1);
                end
            end
            Q_MEAS_LO: begin
                if (flag_hi && flag_lo) begin
                    r_d.st = Q_ABORT;
                    r_d.w  = '0;
                end else if (flag_lo) begin
                    if (r_q.w != W_SAT) r_d.w = r_q.w + 1'b1;
                end else begin
                    r_d.up = (r_q.w == W_SAT);
                    r_d.st = Q_IDLE;
                    r_d.w  = '0;
                end
            end
            Q_MEAS_HI: begin
                if (flag_hi && flag_lo) begin
                    r_d.st = Q_ABORT;
                    r_d.w  = '0;
                end else if (flag_hi) begin
                    if (r_q.w != W_SAT) r_d.w = r_q.w + 1'b1;
                end else begin
                    r_d.dn = (r_q.w == W_SAT);
                    r_d.st = Q_IDLE;
                    r_d.w  = '0;
                end
            end
            default: begin
                r_d.w = '0;
                if (!flag_hi && !flag_lo) r_d.st = Q_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st <= Q_IDLE;
            r_q.w  <= '0;
            r_q.up <= 1'b0;
            r_q.dn <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign step_up = r_q.up;
    assign step_dn = r_q.dn;

    // R10: width measurement saturates rather than wrapping
    p_width_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.w <= W_SAT);

    // R2 / R3: never both directions at once
    p_step_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({r_q.up, r_q.dn}));

    // R4: a step only follows a width beyond the reject limit
    p_short_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.up || r_q.dn) |-> ($past(r_q.w) > CW'(REJECT_CYC)));

    // R11: an aborted measurement produces no step
    p_abort_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == Q_ABORT) |=> !(r_q.up || r_q.dn));

endmodule

// File: rtl/trim_sat_counter.sv
module trim_sat_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] nv_data,
    input  logic         enable,
    input  logic         step_up,
    input  logic         step_dn,
    output logic [W-1:0] value,
    output logic         loaded
);

    localparam logic [W-1:0] VMAX = {W{1'b1}};
    localparam logic [W-1:0] VMIN = '0;

    typedef struct packed {
        logic [W-1:0] val;
        logic         loaded;
        logic         armed;
    } cnt_regs_t;

    cnt_regs_t c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (!c_q.loaded) begin
            c_d.val    = nv_data;
            c_d.loaded = 1'b1;
        end else if (enable && (step_up || step_dn)) begin
            if (!c_q.armed) begin
                c_d.armed = 1'b1;
            end else if (step_up) begin
                if (c_q.val != VMAX) c_d.val = c_q.val + 1'b1;
            end else begin
                if (c_q.val != VMIN) c_d.val = c_q.val - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.val    <= '0;
            c_q.loaded <= 1'b0;
            c_q.armed  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign value  = c_q.val;
    assign loaded = c_q.loaded;

    // R2 / R3: once loaded the setting moves by at most one per cycle
    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.loaded && $past(c_q.loaded)) |->
            (({1'b0, c_q.val} == {1'b0, $past(c_q.val)}) ||
             ({1'b0, c_q.val} == {1'b0, $past(c_q.val)} + 1'b1) ||
             ({1'b0, c_q.val} + 1'b1 == {1'b0, $past(c_q.val)})));

    // R6: no wrap from the top
    p_no_wrap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.loaded && c_q.val == VMAX) |=> (c_q.val != VMIN));

    // R7: no wrap from the bottom
    p_no_wrap_bot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.loaded && c_q.val == VMIN) |=> (c_q.val != VMAX));

    // R8: disabled means frozen
    p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.loaded && !enable) |=> $stable(c_q.val));

    // R5: before the discard is used up the setting cannot move
    p_first_discard_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.loaded && !c_q.armed) |=> $stable(c_q.val));

    // R1: loading completes one cycle after reset release
    p_load_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !c_q.loaded |=> c_q.loaded);

endmodule

// File: rtl/trim_store.sv
module trim_store #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         prog,
    input  logic         loaded,
    input  logic [W-1:0] value,
    output logic         store_req,
    output logic [W-1:0] store_data
);

    typedef struct packed {
        logic         prog_prev;
        logic         req;
        logic [W-1:0] data;
    } st_regs_t;

    st_regs_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        s_d.prog_prev = prog;
        s_d.req       = prog && !s_q.prog_prev && loaded;
        if (s_d.req) s_d.data = value;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.prog_prev <= 1'b0;
            s_q.req       <= 1'b0;
            s_q.data      <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign store_req  = s_q.req;
    assign store_data = s_q.data;

    // R9: one request per strobe
    p_store_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.req |=> !s_q.req);

    // R9: request carries the setting of the strobe cycle
    p_store_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.req |-> (s_q.data == $past(value)));

endmodule

// File: rtl/trim_ctrl_top.sv
module trim_ctrl_top #(
    parameter int CLK_HZ    = 10_000_000,
    parameter int ACCEPT_US = 200,
    parameter int REJECT_US = 20,
    parameter int W         = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ctl_hi_raw,
    input  logic         ctl_lo_raw,
    input  logic         enable,
    input  logic         prog,
    input  logic [W-1:0] nv_data,
    output logic [W-1:0] setting,
    output logic         store_req,
    output logic [W-1:0] store_data
);

    logic [1:0]   flags_sync;
    logic         step_up, step_dn;
    logic         loaded;
    logic [W-1:0] value;

    trim_sync #(.NBITS(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ctl_hi_raw, ctl_lo_raw}),
        .sync_o  (flags_sync)
    );

    trim_pulse_qual #(
        .CLK_HZ    (CLK_HZ),
        .ACCEPT_US (ACCEPT_US),
        .REJECT_US (REJECT_US)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .flag_hi (flags_sync[1]),
        .flag_lo (flags_sync[0]),
        .step_up (step_up),
        .step_dn (step_dn)
    );

    trim_sat_counter #(.W(W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .nv_data (nv_data),
        .enable  (enable),
        .step_up (step_up),
        .step_dn (step_dn),
        .value   (value),
        .loaded  (loaded)
    );

    trim_store #(.W(W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog       (prog),
        .loaded     (loaded),
        .value      (value),
        .store_req  (store_req),
        .store_data (store_data)
    );

    assign setting = value;

endmodule

// File: tb/trim_ctrl_top_tb_top.sv
module trim_ctrl_top_tb_top;

    localparam int CLK_HZ = 1_000_000;
    localparam int ACC    = (CLK_HZ / 1000) * 200 / 1000;
    localparam int REJ    = (CLK_HZ / 1000) * 20 / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_hi_raw = 1'b0;
    logic       ctl_lo_raw = 1'b0;
    logic       enable = 1'b1;
    logic       prog = 1'b0;
    logic [6:0] nv_data = 7'd0;
    logic [6:0] setting;
    logic       store_req;
    logic [6:0] store_data;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int req_cnt = 0;
    logic [6:0] req_data = '0;

    always #2.5 clk = ~clk;

    trim_ctrl_top #(.CLK_HZ(CLK_HZ)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_hi_raw (ctl_hi_raw),
        .ctl_lo_raw (ctl_lo_raw),
        .enable     (enable),
        .prog       (prog),
        .nv_data    (nv_data),
        .setting    (setting),
        .store_req  (store_req),
        .store_data (store_data)
    );

    always @(negedge clk) begin
        if (store_req) begin
            req_cnt  <= req_cnt + 1;
            req_data <= store_data;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190_000) begin
            fails = fails + 1;
            $display("FAIL watchdog: actual %0d cycles, expected completion", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic power_on(input logic [6:0] nv);
        @(negedge clk);
        rst_n   = 1'b0;
        nv_data = nv;
        idle(3);
        rst_n = 1'b1;
        idle(4);
    endtask

    // lo_not_hi = 1 drives a low pulse (increment request)
    task automatic pulse(input bit lo_not_hi, input int n);
        @(negedge clk);
        if (lo_not_hi) ctl_lo_raw = 1'b1;
        else           ctl_hi_raw = 1'b1;
        idle(n);
        ctl_lo_raw = 1'b0;
        ctl_hi_raw = 1'b0;
        idle(12);
    endtask

    task automatic t_reset_load();
        power_on(7'd50);
        check("R1 setting after power-on", setting, 50);
        check("R1 store_req idle", store_req, 0);
    endtask

    task automatic t_first_discard();
        pulse(1, ACC + 50);
        check("R5 first qualified pulse discarded", setting, 50);
        pulse(1, ACC + 50);
        check("R2 low pulse increments", setting, 51);
        pulse(0, ACC + 50);
        check("R3 high pulse decrements", setting, 50);
    endtask

    task automatic t_reject();
        pulse(1, REJ / 2);
        check("R4 glitch below reject limit", setting, 50);
        pulse(0, REJ - 1);
        check("R4 high glitch below reject limit", setting, 50);
        pulse(1, ACC - 50);
        check("R4 pulse between limits", setting, 50);
        pulse(1, ACC);
        check("R4 pulse exactly at accept limit", setting, 50);
        pulse(1, ACC + 1);
        check("R2 pulse one cycle beyond limit", setting, 51);
    endtask

    task automatic t_long();
        pulse(1, ACC * 10);
        check("R10 long pulse gives one step", setting, 52);
    endtask

    task automatic t_disable();
        @(negedge clk) enable = 1'b0;
        pulse(1, ACC + 50);
        check("R8 low pulse while disabled", setting, 52);
        pulse(0, ACC + 50);
        check("R8 high pulse while disabled", setting, 52);
        @(negedge clk) enable = 1'b1;
        idle(2);
    endtask

    task automatic t_abort();
        @(negedge clk) ctl_lo_raw = 1'b1;
        idle(ACC / 2);
        ctl_hi_raw = 1'b1;
        idle(20);
        ctl_hi_raw = 1'b0;
        idle(ACC);
        ctl_lo_raw = 1'b0;
        idle(12);
        check("R11 both flags abort measurement", setting, 52);
        pulse(1, ACC + 50);
        check("R11 normal pulse after abort", setting, 53);
    endtask

    task automatic t_program();
        req_cnt = 0;
        @(negedge clk) prog = 1'b1;
        idle(6);
        prog = 1'b0;
        idle(3);
        check("R9 one store request per strobe", req_cnt, 1);
        check("R9 store data equals setting", req_data, 53);
        check("R9 request released", store_req, 0);
    endtask

    task automatic t_sat_top();
        power_on(7'd126);
        check("R1 load 126", setting, 126);
        pulse(1, ACC + 30);
        pulse(1, ACC + 30);
        check("R6 step to 127", setting, 127);
        pulse(1, ACC + 30);
        check("R6 hold at 127", setting, 127);
    endtask

    task automatic t_sat_bottom();
        power_on(7'd1);
        pulse(0, ACC + 30);
        check("R5 discard after new power-on", setting, 1);
        pulse(0, ACC + 30);
        check("R7 step to 0", setting, 0);
        pulse(0, ACC + 30);
        check("R7 hold at 0", setting, 0);
    endtask

    task automatic t_disable_keeps_discard();
        power_on(7'd10);
        @(negedge clk) enable = 1'b0;
        pulse(1, ACC + 30);
        @(negedge clk) enable = 1'b1;
        idle(2);
        pulse(1, ACC + 30);
        check("R8 disabled pulse leaves discard pending", setting, 10);
        pulse(1, ACC + 30);
        check("R8 next pulse acts", setting, 11);
    endtask

    initial begin
        t_reset_load();
        t_first_discard();
        t_reject();
        t_long();
        t_disable();
        t_abort();
        t_program();
        t_sat_top();
        t_sat_bottom();
        t_disable_keeps_discard();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule